// File: doc/BRIEF.md
# Root Port Error Collector

This block sits at the top of a root port's error path. Error messages arrive on a
valid/ready stream, each one carrying a severity code and the 16-bit source
identifier of the function that reported it. For each accepted message the
collector updates a root error status register and a source identification
register. Both registers separate the first occurrence of a class from any later
ones: the first message captures the source identifier, and a later one only sets
a "multiple" flag. The collector also records whether the first uncorrectable
message was fatal.

Software enables interrupt generation per class through a three-bit root command
register. It clears status flags by writing ones to them. The collector keeps an
interrupt condition: at least one enabled class has a received flag set. When a
message-signalled mode is selected, it emits a one-cycle interrupt request on the
edge at which that condition turns true. The edge can come from a message arrival
or from a command write. When neither message mode is selected, it drives a level
interrupt line equal to the condition. A device-specific input loads the
interrupt message number. Every request carries that number.

The message stream has no back-pressure in normal operation. `msg_ready` is low
only while the block is in reset and during the first clock after reset is
released. From then on it stays high and one message is accepted per cycle. The
interrupt request output is a single-cycle strobe with no ready. The message
writer downstream must take it on the cycle it appears.

Top module: `root_err_collector`

## Requirements
- R1: `msg_ready` is low in reset, then high from the first clock after reset on. A message is taken on each cycle where `msg_valid` and `msg_ready` are both high.
- R2: Severity code 0 is correctable. If status bit 0 is already set, the message sets bit 1 and leaves the correctable source (`src_rd[15:0]`) unchanged. Otherwise it loads its source into `src_rd[15:0]`. Either way it then sets bit 0.
- R3: Severity code 1 is non-fatal and sets status bit 5. Codes 1 and 2 are uncorrectable. If status bit 2 is already set, an uncorrectable message sets bit 3 and leaves `src_rd[31:16]` unchanged. Otherwise it loads its source into `src_rd[31:16]`. Either way it then sets bit 2.
- R4: Severity code 2 is fatal and sets status bit 6. It also sets bit 4 (first-fatal), but only when bit 2 was clear before the message.
- R5: A message with severity code 3 is accepted and changes no register and no output.
- R6: Status bits 6:0 are write-one-to-clear through `sts_w1c_en`/`sts_w1c_data`, and a zero bit leaves its flag alone. When a clear and a message land in the same cycle, the clear is applied first. The message then sees the cleared flags, so a cleared class counts as first again.
- R7: A write on `cmd_we` loads `cmd_rd`, and reset clears it. Bit 0 enables the correctable class (status bit 0), bit 1 the non-fatal class (status bit 5), and bit 2 the fatal class (status bit 6).
- R8: The interrupt condition is the OR of the enabled received classes. In a message mode, `irq_valid` pulses for one cycle, in the cycle after the edge at which the condition goes from false to true. An arriving message therefore raises a request only if its class is enabled and no enabled class was already received. A command write raises one only if the new enables meet a received class that the old ones did not.
- R9: `msix_en` takes priority over `msi_en`. `irq_is_msix` is 1 on a request made while `msix_en` was high, and 0 on one made under `msi_en` alone.
- R10: While both `msix_en` and `msi_en` are low, `intx` equals the interrupt condition. It rises after an enabled message or a command write, and falls when the flags are cleared or the enables are removed. It is 0 in either message mode.
- R11: The message number is `sts_rd[31:27]`. It is loaded only from `vec_in` on `vec_load`, a status write cannot change it, and every request carries it on `irq_vector`.
- R12: After reset the status register, the source register, the command register, `intx` and `irq_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Error message present |
| msg_ready | output | 1 | Collector accepts a message |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 reserved |
| msg_src | input | SRC_W | Requester source identifier |
| cmd_we | input | 1 | Root command write strobe |
| cmd_wdata | input | 3 | Root command write data |
| sts_w1c_en | input | 1 | Status write-one-to-clear strobe |
| sts_w1c_data | input | 32 | Status write data (bits 6:0 effective) |
| vec_load | input | 1 | Load interrupt message number |
| vec_in | input | 5 | Device-specific interrupt message number |
| msix_en | input | 1 | MSI-X delivery selected |
| msi_en | input | 1 | MSI delivery selected |
| cmd_rd | output | 3 | Root command register |
| sts_rd | output | 32 | Root error status register |
| src_rd | output | 2*SRC_W | Source identification: uncorrectable high, correctable low |
| irq_valid | output | 1 | One-cycle interrupt message request |
| irq_is_msix | output | 1 | Request is for MSI-X |
| irq_vector | output | 5 | Message number of the request |
| intx | output | 1 | Level interrupt line |

## Verification
Several properties are checked on every cycle by assertions:

- a captured source identifier stays put while its class flag is held;
- first-fatal only ever rises together with fatal and uncorrectable;
- a flag stays set until it is written to clear;
- a reserved severity changes nothing;
- each request is a lone pulse that follows a false-to-true change of the condition and occurs only in a message mode.

Other behaviours can only be shown by the bench scenarios. These include the exact captured identifier values and the first-versus-multiple ordering across class pairs. They also include the result when a clear and a message land in the same cycle, and the absence of a request when the condition was already true. The last group is the exact cycles at which the level line follows command writes and clears.

// File: rtl/rpec_pkg.sv
package rpec_pkg;
  localparam int STS_W   = 32;
  localparam int FLG_W   = 7;
  localparam int CMD_W   = 3;
  localparam int VEC_W   = 5;
  localparam int VEC_LSB = STS_W - VEC_W;
  localparam int PAD_W   = STS_W - VEC_W - FLG_W;

  // status flag positions
  localparam int F_COR  = 0;
  localparam int F_MCOR = 1;
  localparam int F_UNC  = 2;
  localparam int F_MUNC = 3;
  localparam int F_FFAT = 4;
  localparam int F_NF   = 5;
  localparam int F_FAT  = 6;

  // command enable positions
  localparam int E_COR = 0;
  localparam int E_NF  = 1;
  localparam int E_FAT = 2;

  typedef enum logic [1:0] {
    SEV_COR   = 2'd0,
    SEV_NF    = 2'd1,
    SEV_FAT   = 2'd2,
    SEV_RSVD  = 2'd3
  } sev_e;

  // received classes mapped onto the command enable positions
  function automatic logic [CMD_W-1:0] rcv_to_en(input logic [FLG_W-1:0] f);
    logic [CMD_W-1:0] r;
    r        = '0;
    r[E_COR] = f[F_COR];
    r[E_NF]  = f[F_NF];
    r[E_FAT] = f[F_FAT];
    return r;
  endfunction
endpackage

// File: rtl/rpec_flags.sv
module rpec_flags
  import rpec_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  sev_e             sev,
  input  logic [SRC_W-1:0] src,
  input  logic             w1c_en,
  input  logic [FLG_W-1:0] w1c_bits,
  output logic [FLG_W-1:0] flg_q,
  output logic [FLG_W-1:0] flg_d,
  output logic [SRC_W-1:0] cor_src_q,
  output logic [SRC_W-1:0] unc_src_q
);
  logic [FLG_W-1:0] kept;
  logic [SRC_W-1:0] cor_src_d;
  logic [SRC_W-1:0] unc_src_d;
  logic             is_cor;
  logic             is_nf;
  logic             is_fat;

  assign is_cor = acc && (sev == SEV_COR);
  assign is_nf  = acc && (sev == SEV_NF);
  assign is_fat = acc && (sev == SEV_FAT);

  always_comb begin
    kept      = w1c_en ? (flg_q & ~w1c_bits) : flg_q;
    flg_d     = kept;
    cor_src_d = cor_src_q;
    unc_src_d = unc_src_q;
    if (is_cor) begin
      if (kept[F_COR]) flg_d[F_MCOR] = 1'b1;
      else             cor_src_d     = src;
      flg_d[F_COR] = 1'b1;
    end
    if (is_nf) flg_d[F_NF] = 1'b1;
    if (is_fat) begin
      if (!kept[F_UNC]) flg_d[F_FFAT] = 1'b1;
      flg_d[F_FAT] = 1'b1;
    end
    if (is_nf || is_fat) begin
      if (kept[F_UNC]) flg_d[F_MUNC] = 1'b1;
      else             unc_src_d     = src;
      flg_d[F_UNC] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q     <= '0;
      cor_src_q <= '0;
      unc_src_q <= '0;
    end else begin
      flg_q     <= flg_d;
      cor_src_q <= cor_src_d;
      unc_src_q <= unc_src_d;
    end
  end

  AST_COR_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q[F_COR] && !(w1c_en && w1c_bits[F_COR])) |=> $stable(cor_src_q)); // R2

  AST_UNC_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q[F_UNC] && !(w1c_en && w1c_bits[F_UNC])) |=> $stable(unc_src_q)); // R3

  AST_FFAT_WITH_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[F_FFAT]) |-> (flg_q[F_FAT] && flg_q[F_UNC])); // R4

  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sev == SEV_RSVD && !w1c_en) |=> $stable(flg_q)); // R5

  for (genvar gi = 0; gi < FLG_W; gi++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_q[gi] && !(w1c_en && w1c_bits[gi])) |=> flg_q[gi]); // R6
  end
endmodule

// File: rtl/rpec_ctrl.sv
module rpec_ctrl
  import rpec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             vec_load,
  input  logic [VEC_W-1:0] vec_in,
  output logic [CMD_W-1:0] cmd_q,
  output logic [CMD_W-1:0] cmd_d,
  output logic [VEC_W-1:0] vec_q,
  output logic             ready_q
);
  assign cmd_d = cmd_we ? cmd_wdata : cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      vec_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      ready_q <= 1'b1;
      if (vec_load) vec_q <= vec_in;
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(cmd_q)); // R7

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_load |=> $stable(vec_q)); // R11
endmodule

// File: rtl/rpec_irq.sv
module rpec_irq
  import rpec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] cmd_q,
  input  logic [CMD_W-1:0] cmd_d,
  input  logic [FLG_W-1:0] flg_q,
  input  logic [FLG_W-1:0] flg_d,
  input  logic [VEC_W-1:0] vec_q,
  input  logic             msix_en,
  input  logic             msi_en,
  output logic             irq_valid,
  output logic             irq_is_msix,
  output logic [VEC_W-1:0] irq_vector,
  output logic             intx
);
  logic cond_q;
  logic cond_d;
  logic msg_mode;

  assign cond_q   = |(cmd_q & rcv_to_en(flg_q));
  assign cond_d   = |(cmd_d & rcv_to_en(flg_d));
  assign msg_mode = msix_en || msi_en;
  assign intx     = !msg_mode && cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid   <= 1'b0;
      irq_is_msix <= 1'b0;
      irq_vector  <= '0;
    end else begin
      irq_valid   <= msg_mode && !cond_q && cond_d;
      irq_is_msix <= msix_en;
      irq_vector  <= vec_q;
    end
  end

  AST_PULSE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (cond_q && !$past(cond_q))); // R8

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid); // R8

  AST_PULSE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(msix_en || msi_en)); // R9

  AST_PULSE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == $past(vec_q))); // R11
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
  import rpec_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  output logic               msg_ready,
  input  logic [1:0]         msg_sev,
  input  logic [SRC_W-1:0]   msg_src,
  input  logic               cmd_we,
  input  logic [2:0]         cmd_wdata,
  input  logic               sts_w1c_en,
  input  logic [31:0]        sts_w1c_data,
  input  logic               vec_load,
  input  logic [4:0]         vec_in,
  input  logic               msix_en,
  input  logic               msi_en,
  output logic [2:0]         cmd_rd,
  output logic [31:0]        sts_rd,
  output logic [2*SRC_W-1:0] src_rd,
  output logic               irq_valid,
  output logic               irq_is_msix,
  output logic [4:0]         irq_vector,
  output logic               intx
);
  logic [FLG_W-1:0] flg_q;
  logic [FLG_W-1:0] flg_d;
  logic [SRC_W-1:0] cor_src_q;
  logic [SRC_W-1:0] unc_src_q;
  logic [CMD_W-1:0] cmd_q;
  logic [CMD_W-1:0] cmd_d;
  logic [VEC_W-1:0] vec_q;
  logic             ready_q;
  logic             acc;

  assign msg_ready = ready_q;
  assign acc       = msg_valid && ready_q;

  rpec_flags #(.SRC_W(SRC_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .sev       (sev_e'(msg_sev)),
    .src       (msg_src),
    .w1c_en    (sts_w1c_en),
    .w1c_bits  (sts_w1c_data[FLG_W-1:0]),
    .flg_q     (flg_q),
    .flg_d     (flg_d),
    .cor_src_q (cor_src_q),
    .unc_src_q (unc_src_q)
  );

  rpec_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_wdata (cmd_wdata),
    .vec_load  (vec_load),
    .vec_in    (vec_in),
    .cmd_q     (cmd_q),
    .cmd_d     (cmd_d),
    .vec_q     (vec_q),
    .ready_q   (ready_q)
  );

  rpec_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_q       (cmd_q),
    .cmd_d       (cmd_d),
    .flg_q       (flg_q),
    .flg_d       (flg_d),
    .vec_q       (vec_q),
    .msix_en     (msix_en),
    .msi_en      (msi_en),
    .irq_valid   (irq_valid),
    .irq_is_msix (irq_is_msix),
    .irq_vector  (irq_vector),
    .intx        (intx)
  );

  assign cmd_rd = cmd_q;
  assign sts_rd = {vec_q, {PAD_W{1'b0}}, flg_q};
  assign src_rd = {unc_src_q, cor_src_q};
endmodule

// File: tb/test_root_err_collector.sv
`timescale 1ns/1ps
module test_root_err_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic [1:0]  msg_sev = '0;
  logic [15:0] msg_src = '0;
  logic        cmd_we = 1'b0;
  logic [2:0]  cmd_wdata = '0;
  logic        sts_w1c_en = 1'b0;
  logic [31:0] sts_w1c_data = '0;
  logic        vec_load = 1'b0;
  logic [4:0]  vec_in = '0;
  logic        msix_en = 1'b0;
  logic        msi_en = 1'b0;
  logic [2:0]  cmd_rd;
  logic [31:0] sts_rd;
  logic [31:0] src_rd;
  logic        irq_valid;
  logic        irq_is_msix;
  logic [4:0]  irq_vector;
  logic        intx;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic [6:0]  e_flg = '0;
  logic [15:0] e_cor = '0;
  logic [15:0] e_unc = '0;
  logic [2:0]  e_cmd = '0;
  logic [4:0]  e_vec = '0;

  always #4 clk = ~clk;

  root_err_collector i_root_err_collector (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_sev(msg_sev), .msg_src(msg_src), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .sts_w1c_en(sts_w1c_en), .sts_w1c_data(sts_w1c_data), .vec_load(vec_load),
    .vec_in(vec_in), .msix_en(msix_en), .msi_en(msi_en), .cmd_rd(cmd_rd),
    .sts_rd(sts_rd), .src_rd(src_rd), .irq_valid(irq_valid),
    .irq_is_msix(irq_is_msix), .irq_vector(irq_vector), .intx(intx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // enabled-class view of the flags: cmd0 <-> bit0, cmd1 <-> bit5, cmd2 <-> bit6
  function automatic logic [2:0] cls(input logic [6:0] f);
    return {f[6], f[5], f[0]};
  endfunction

  function automatic string sev_tag(input logic v, input logic [1:0] s);
    if (!v) return "R6";
    case (s)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // one clock: drive, predict, compare every output
  task automatic drive(input logic v, input logic [1:0] sv, input logic [15:0] sr,
                       input logic ce, input logic [6:0] cb,
                       input logic we, input logic [2:0] wd,
                       input logic vl, input logic [4:0] vv, input string tag);
    logic [6:0]  f;
    logic [15:0] nc, nu;
    logic [2:0]  ncmd;
    logic        co, cn, ep, em;
    logic [4:0]  ev;
    msg_valid = v; msg_sev = sv; msg_src = sr;
    sts_w1c_en = ce; sts_w1c_data = {5'h1f, 20'hfffff, cb};
    cmd_we = we; cmd_wdata = wd; vec_load = vl; vec_in = vv;
    f = ce ? (e_flg & ~cb) : e_flg;
    nc = e_cor; nu = e_unc;
    if (v && sv == 2'd0) begin
      if (f[0]) f[1] = 1'b1; else nc = sr;
      f[0] = 1'b1;
    end
    if (v && sv == 2'd1) f[5] = 1'b1;
    if (v && sv == 2'd2) begin
      if (!f[2]) f[4] = 1'b1;
      f[6] = 1'b1;
    end
    if (v && (sv == 2'd1 || sv == 2'd2)) begin
      if (f[2]) f[3] = 1'b1; else nu = sr;
      f[2] = 1'b1;
    end
    ncmd = we ? wd : e_cmd;
    co = |(e_cmd & cls(e_flg));
    cn = |(ncmd & cls(f));
    ep = (msix_en || msi_en) && !co && cn;
    em = msix_en;
    ev = e_vec;
    @(posedge clk);
    @(negedge clk);
    msg_valid = 1'b0; sts_w1c_en = 1'b0; cmd_we = 1'b0; vec_load = 1'b0;
    e_flg = f; e_cor = nc; e_unc = nu; e_cmd = ncmd;
    if (vl) e_vec = vv;
    chk(tag, sts_rd, {e_vec, 20'd0, e_flg});
    chk(tag, src_rd, {e_unc, e_cor});
    chk("R7", {29'd0, cmd_rd}, {29'd0, e_cmd});
    chk("R8", {31'd0, irq_valid}, {31'd0, ep});
    if (ep) begin
      chk("R9", {31'd0, irq_is_msix}, {31'd0, em});
      chk("R11", {27'd0, irq_vector}, {27'd0, ev});
    end
    chk("R10", {31'd0, intx}, {31'd0, (!msix_en && !msi_en && cn)});
    chk("R1", {31'd0, msg_ready}, 32'd1);
  endtask

  task automatic msg(input logic [1:0] sv, input logic [15:0] sr);
    drive(1'b1, sv, sr, 1'b0, 7'd0, 1'b0, 3'd0, 1'b0, 5'd0, sev_tag(1'b1, sv));
  endtask

  task automatic clr(input logic [6:0] b);
    drive(1'b0, 2'd0, 16'd0, 1'b1, b, 1'b0, 3'd0, 1'b0, 5'd0, "R6");
  endtask

  task automatic wcmd(input logic [2:0] c);
    drive(1'b0, 2'd0, 16'd0, 1'b0, 7'd0, 1'b1, c, 1'b0, 5'd0, "R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state, R1 ready low in reset
    chk("R12", sts_rd, 32'd0);
    chk("R12", src_rd, 32'd0);
    chk("R12", {29'd0, cmd_rd}, 32'd0);
    chk("R12", {30'd0, intx, irq_valid}, 32'd0);
    chk("R1", {31'd0, msg_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {31'd0, msg_ready}, 32'd1);

    // R11 vector load; a status write with bits 31:27 set must not touch it
    drive(1'b0, 2'd0, 16'd0, 1'b0, 7'd0, 1'b0, 3'd0, 1'b1, 5'd19, "R11");
    clr(7'h7f);

    // R6 same-cycle clear and arrival: cleared class counts as first again
    msg(2'd0, 16'hA001);
    drive(1'b1, 2'd0, 16'hA002, 1'b1, 7'h01, 1'b0, 3'd0, 1'b0, 5'd0, "R6");
    drive(1'b1, 2'd2, 16'hB003, 1'b1, 7'h04, 1'b0, 3'd0, 1'b0, 5'd0, "R6");
    clr(7'h00);
    clr(7'h7f);

    // R10 level line follows command writes and clears
    msg(2'd1, 16'hC001);
    wcmd(3'b010);
    wcmd(3'b001);
    wcmd(3'b110);
    clr(7'h20);
    clr(7'h7f);
    wcmd(3'b000);

    // R8 message-mode edges from command writes
    msi_en = 1'b1;
    msg(2'd0, 16'hD001);
    wcmd(3'b001);
    wcmd(3'b011);
    msg(2'd1, 16'hD002);
    wcmd(3'b000);
    wcmd(3'b010);
    clr(7'h7f);
    wcmd(3'b000);
    msi_en = 1'b0;

    // near-exhaustive sweep: mode x command x first severity x second severity
    for (int m = 0; m < 3; m++) begin
      msi_en  = (m >= 1);
      msix_en = (m == 2);
      drive(1'b0, 2'd0, 16'd0, 1'b0, 7'd0, 1'b0, 3'd0, 1'b1, 5'(m * 7 + 3), "R11");
      for (int c = 0; c < 8; c++) begin
        for (int s1 = 0; s1 < 4; s1++) begin
          for (int s2 = 0; s2 < 4; s2++) begin
            clr(7'h7f);
            wcmd(3'(c));
            msg(2'(s1), 16'(16'h1000 + m * 256 + c * 16 + s1));
            msg(2'(s2), 16'(16'h8000 + m * 256 + c * 16 + s2));
          end
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule